// File: doc/BRIEF.md
# Compacting Age-Ordered Issue Column

One column of a banked out-of-order issue window. Entries sit in a stack ordered by age, with the oldest at position 0. Each entry carries an opaque payload and one source tag. That tag is the register index inside the preceding column, which is the only column that can wake it. An entry may also be marked as the second half of a split instruction. In that case it carries a short second-part tag and stays asleep until a matching second-part wakeup arrives.

The column takes at most one new entry per cycle and issues at most one per cycle, always the oldest eligible entry. An issued entry keeps its slot until a completion confirmation names its position. A replay can re-arm it before then. When an entry is confirmed, the entries above it move down one place to close the gap, and a dispatch in the same cycle lands on top of the compacted stack. Two inputs take priority over normal issue: a returning cache miss holds the write port, and a flush trims the young end of the stack.

Top module: `issue_column`

## Requirements
- R1: A dispatch is accepted when `disp_valid_i` is high, `full_o` is low and `flush_i` is low. At most one entry is accepted per cycle, and it becomes the youngest entry.
- R2: An entry is eligible when it is valid, not issued, has its source ready, and is either not a second part or has its second part woken. `issue_valid_o` flags the lowest eligible position, which is the oldest. `issue_idx_o` gives that position (0 = oldest), and `issue_payload_o` gives its payload, in the same cycle.
- R3: `done_valid_i` naming a valid position removes that entry at the next edge. Entries below it keep their place, entries above it move down one place, and age order is preserved. A dispatch in the same cycle goes on top. A done that names an empty position is ignored.
- R4: A neighbour wakeup sets the source-ready bit of every entry whose source tag equals `nbr_wake_tag_i`, including an entry dispatched in that same cycle. The entry can issue from the following cycle.
- R5: An entry dispatched with `disp_is_p2_i` high does not issue until `p2_wake_valid_i` arrives with `p2_wake_tag_i` equal to its second-part tag. Wakeups with other tags have no effect on it.
- R6: An issued entry stays resident and is not selected again. `replay_valid_i` clears the issued mark of the named position, which makes that entry eligible again.
- R7: While `miss_req_i` is high, `issue_valid_o` is low and no entry is marked issued.
- R8: `full_o` is high exactly when every position is valid and no done is removing an entry in that cycle. A dispatch in a full cycle that has no done is dropped.
- R9: While `flush_i` is high, every entry at a position equal to or above `flush_keep_i` is discarded. Dispatch, done and issue are all suppressed in that cycle.
- R10: After reset the column is empty, `issue_valid_o` is low and `full_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_payload_i | input | PAYLOAD_W | Payload of the dispatched entry |
| disp_src_tag_i | input | SRC_TAG_W | Source register index in the preceding column |
| disp_src_rdy_i | input | 1 | Source already available at dispatch |
| disp_is_p2_i | input | 1 | Entry is a second part |
| disp_p2_tag_i | input | P2_TAG_W | Second-part tag |
| full_o | output | 1 | Dispatch cannot be accepted this cycle |
| nbr_wake_valid_i | input | 1 | Neighbour result broadcast |
| nbr_wake_tag_i | input | SRC_TAG_W | Broadcast register index |
| p2_wake_valid_i | input | 1 | Second-part wakeup |
| p2_wake_tag_i | input | P2_TAG_W | Second-part wakeup tag |
| miss_req_i | input | 1 | Cache-miss return holds the write port |
| issue_valid_o | output | 1 | An entry issues this cycle |
| issue_idx_o | output | $clog2(DEPTH) | Stack position of the issuing entry |
| issue_payload_o | output | PAYLOAD_W | Payload of the issuing entry |
| done_valid_i | input | 1 | Completion confirmed |
| done_idx_i | input | $clog2(DEPTH) | Position of the confirmed entry |
| replay_valid_i | input | 1 | Re-arm request |
| replay_idx_i | input | $clog2(DEPTH) | Position to re-arm |
| flush_i | input | 1 | Discard young entries |
| flush_keep_i | input | $clog2(DEPTH+1) | Number of oldest entries kept |

## Verification
The bench builds the column with DEPTH=4. At that size the full condition and the move of the top slot during compaction come up every few dozen cycles of random traffic. It also exercises a done and a dispatch in the same full cycle, which must both take effect. Random source tags are limited to four values, so neighbour wakeups often match several entries at once. This shows that selection keeps to age order when more than one entry becomes ready together. Done and replay positions are drawn over the whole index range, so empty positions are named often enough to test that such requests are ignored.

// File: rtl/ic_pkg.sv
package ic_pkg;
  parameter int PAYLOAD_W = 16;
  parameter int SRC_TAG_W = 4;
  parameter int P2_TAG_W  = 3;

  typedef struct packed {
    logic                 valid;
    logic                 issued;
    logic [PAYLOAD_W-1:0] payload;
    logic [SRC_TAG_W-1:0] src_tag;
    logic                 src_rdy;
    logic                 is_p2;
    logic [P2_TAG_W-1:0]  p2_tag;
    logic                 p2_rdy;
  } ic_entry_t;
endpackage

// File: rtl/ic_entry_next.sv
module ic_entry_next
  import ic_pkg::*;
(
  input  ic_entry_t            cur_i,
  input  logic                 nbr_wake_i,
  input  logic [SRC_TAG_W-1:0] nbr_tag_i,
  input  logic                 p2_wake_i,
  input  logic [P2_TAG_W-1:0]  p2_tag_i,
  input  logic                 set_issued_i,
  input  logic                 clr_issued_i,
  output ic_entry_t            nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (nbr_wake_i && (cur_i.src_tag == nbr_tag_i)) nxt_o.src_rdy = 1'b1;
    if (p2_wake_i && cur_i.is_p2 && (cur_i.p2_tag == p2_tag_i)) nxt_o.p2_rdy = 1'b1;
    nxt_o.issued = (cur_i.issued & ~clr_issued_i) | set_issued_i;
  end
endmodule

// File: rtl/ic_select.sv
module ic_select #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic             en_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  // fixed priority: position 0 is oldest
  always_comb begin
    gnt_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_idx_o = IDX_W'(i);
    end
    gnt_valid_o = en_i && (|req_i);
  end
endmodule

// File: rtl/ic_compact.sv
module ic_compact
  import ic_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  ic_entry_t [DEPTH-1:0] upd_i,
  input  logic                  hole_en_i,
  input  logic [IDX_W-1:0]      hole_idx_i,
  input  logic                  ins_en_i,
  input  logic [CNT_W-1:0]      ins_pos_i,
  input  ic_entry_t             ins_i,
  output ic_entry_t [DEPTH-1:0] nxt_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    ic_entry_t above;
    ic_entry_t slot;
    if (g < DEPTH - 1) begin : g_mid
      assign above = upd_i[g+1];
    end else begin : g_top
      assign above = '0;
    end
    always_comb begin
      slot = upd_i[g];
      if (hole_en_i && (g >= int'(hole_idx_i))) slot = above;
      if (ins_en_i && (int'(ins_pos_i) == g)) slot = ins_i;
    end
    assign nxt_o[g] = slot;
  end
endmodule

// File: rtl/issue_column.sv
module issue_column
  import ic_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 disp_valid_i,
  input  logic [PAYLOAD_W-1:0] disp_payload_i,
  input  logic [SRC_TAG_W-1:0] disp_src_tag_i,
  input  logic                 disp_src_rdy_i,
  input  logic                 disp_is_p2_i,
  input  logic [P2_TAG_W-1:0]  disp_p2_tag_i,
  output logic                 full_o,
  input  logic                 nbr_wake_valid_i,
  input  logic [SRC_TAG_W-1:0] nbr_wake_tag_i,
  input  logic                 p2_wake_valid_i,
  input  logic [P2_TAG_W-1:0]  p2_wake_tag_i,
  input  logic                 miss_req_i,
  output logic                 issue_valid_o,
  output logic [IDX_W-1:0]     issue_idx_o,
  output logic [PAYLOAD_W-1:0] issue_payload_o,
  input  logic                 done_valid_i,
  input  logic [IDX_W-1:0]     done_idx_i,
  input  logic                 replay_valid_i,
  input  logic [IDX_W-1:0]     replay_idx_i,
  input  logic                 flush_i,
  input  logic [CNT_W-1:0]     flush_keep_i
);
  ic_entry_t [DEPTH-1:0] ent_q, ent_d, upd, cmp;
  ic_entry_t             disp_raw, disp_upd;
  logic [DEPTH-1:0]      req;
  logic [CNT_W-1:0]      occ;
  logic                  done_fire, disp_fire;

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + CNT_W'(ent_q[i].valid);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign req[g] = ent_q[g].valid && !ent_q[g].issued && ent_q[g].src_rdy &&
                    (!ent_q[g].is_p2 || ent_q[g].p2_rdy);
    ic_entry_next u_next (
      .cur_i        (ent_q[g]),
      .nbr_wake_i   (nbr_wake_valid_i),
      .nbr_tag_i    (nbr_wake_tag_i),
      .p2_wake_i    (p2_wake_valid_i),
      .p2_tag_i     (p2_wake_tag_i),
      .set_issued_i (issue_valid_o && (int'(issue_idx_o) == g)),
      .clr_issued_i (replay_valid_i && (int'(replay_idx_i) == g)),
      .nxt_o        (upd[g])
    );
  end

  ic_select #(.DEPTH(DEPTH)) u_sel (
    .req_i       (req),
    .en_i        (!miss_req_i && !flush_i),
    .gnt_valid_o (issue_valid_o),
    .gnt_idx_o   (issue_idx_o)
  );
  assign issue_payload_o = ent_q[issue_idx_o].payload;

  always_comb begin
    disp_raw         = '0;
    disp_raw.valid   = 1'b1;
    disp_raw.payload = disp_payload_i;
    disp_raw.src_tag = disp_src_tag_i;
    disp_raw.src_rdy = disp_src_rdy_i;
    disp_raw.is_p2   = disp_is_p2_i;
    disp_raw.p2_tag  = disp_p2_tag_i;
  end

  // same-cycle wakeup also catches the incoming entry
  ic_entry_next u_disp_next (
    .cur_i        (disp_raw),
    .nbr_wake_i   (nbr_wake_valid_i),
    .nbr_tag_i    (nbr_wake_tag_i),
    .p2_wake_i    (p2_wake_valid_i),
    .p2_tag_i     (p2_wake_tag_i),
    .set_issued_i (1'b0),
    .clr_issued_i (1'b0),
    .nxt_o        (disp_upd)
  );

  assign done_fire = done_valid_i && ent_q[done_idx_i].valid && !flush_i;
  assign full_o    = (occ == CNT_W'(DEPTH)) && !done_fire;
  assign disp_fire = disp_valid_i && !full_o && !flush_i;

  ic_compact #(.DEPTH(DEPTH)) u_cmp (
    .upd_i      (upd),
    .hole_en_i  (done_fire),
    .hole_idx_i (done_idx_i),
    .ins_en_i   (disp_fire),
    .ins_pos_i  (occ - CNT_W'(done_fire)),
    .ins_i      (disp_upd),
    .nxt_o      (cmp)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_flush
    assign ent_d[g] = (flush_i && (g >= int'(flush_keep_i))) ? '0 : cmp[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= '0;
    else         ent_q <= ent_d;
  end
endmodule

// File: rtl/issue_column_chk.sv
module issue_column_chk #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_o,
  input logic [IDX_W-1:0] issue_idx_o,
  input logic             miss_req_i,
  input logic             full_o,
  input logic             disp_valid_i,
  input logic             done_valid_i,
  input logic [IDX_W-1:0] done_idx_i,
  input logic             replay_valid_i,
  input logic             flush_i,
  input logic [CNT_W-1:0] flush_keep_i,
  input logic [CNT_W-1:0] occ
);
  a_r7_miss_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_req_i |-> !issue_valid_o);

  a_r2_issue_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (int'(issue_idx_o) < int'(occ)));

  a_r8_full_all_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (int'(occ) == DEPTH));

  a_r1_one_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (int'(occ) <= int'($past(occ)) + 1));

  a_r9_flush_trims: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((int'(occ) <= int'($past(flush_keep_i))) && (occ <= $past(occ))));

  a_r3_done_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !flush_i && !disp_valid_i && (int'(done_idx_i) < int'(occ)))
      |=> (int'(occ) == int'($past(occ)) - 1));

  a_r6_no_repeat_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !done_valid_i && !replay_valid_i && !flush_i)
      |=> !(issue_valid_o && (issue_idx_o == $past(issue_idx_o))));
endmodule

bind issue_column issue_column_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .issue_valid_o  (issue_valid_o),
  .issue_idx_o    (issue_idx_o),
  .miss_req_i     (miss_req_i),
  .full_o         (full_o),
  .disp_valid_i   (disp_valid_i),
  .done_valid_i   (done_valid_i),
  .done_idx_i     (done_idx_i),
  .replay_valid_i (replay_valid_i),
  .flush_i        (flush_i),
  .flush_keep_i   (flush_keep_i),
  .occ            (occ)
);

// File: tb/issue_column_test.sv
module issue_column_test;
  import ic_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic disp_valid_i, disp_src_rdy_i, disp_is_p2_i;
  logic [PAYLOAD_W-1:0] disp_payload_i, issue_payload_o;
  logic [SRC_TAG_W-1:0] disp_src_tag_i, nbr_wake_tag_i;
  logic [P2_TAG_W-1:0]  disp_p2_tag_i, p2_wake_tag_i;
  logic full_o, nbr_wake_valid_i, p2_wake_valid_i, miss_req_i, issue_valid_o;
  logic [IDX_W-1:0] issue_idx_o, done_idx_i, replay_idx_i;
  logic done_valid_i, replay_valid_i, flush_i;
  logic [CNT_W-1:0] flush_keep_i;

  int n_vec = 0, n_bad = 0, pay = 1;
  bit finished = 0;
  ic_entry_t mq[$];

  issue_column #(.DEPTH(DEPTH)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid_i = 0; disp_payload_i = '0; disp_src_tag_i = '0; disp_src_rdy_i = 0;
    disp_is_p2_i = 0; disp_p2_tag_i = '0; nbr_wake_valid_i = 0; nbr_wake_tag_i = '0;
    p2_wake_valid_i = 0; p2_wake_tag_i = '0; miss_req_i = 0; done_valid_i = 0;
    done_idx_i = '0; replay_valid_i = 0; replay_idx_i = '0; flush_i = 0; flush_keep_i = '0;
  endtask

  task automatic dispatch(int tag, bit rdy, bit p2, int p2tag);
    disp_valid_i = 1; disp_payload_i = PAYLOAD_W'(pay); pay++;
    disp_src_tag_i = SRC_TAG_W'(tag); disp_src_rdy_i = rdy;
    disp_is_p2_i = p2; disp_p2_tag_i = P2_TAG_W'(p2tag);
  endtask

  function automatic ic_entry_t wake(ic_entry_t e);
    if (nbr_wake_valid_i && e.src_tag == nbr_wake_tag_i) e.src_rdy = 1;
    if (p2_wake_valid_i && e.is_p2 && e.p2_tag == p2_wake_tag_i) e.p2_rdy = 1;
    return e;
  endfunction

  task automatic model_update(int iss, bit full, bit done_ok);
    ic_entry_t e;
    for (int i = 0; i < mq.size(); i++) begin
      e = wake(mq[i]);
      if (replay_valid_i && int'(replay_idx_i) == i) e.issued = 0;
      if (i == iss) e.issued = 1;
      mq[i] = e;
    end
    if (flush_i) begin
      while (mq.size() > int'(flush_keep_i)) void'(mq.pop_back());
      return;
    end
    if (done_ok) mq.delete(int'(done_idx_i));
    if (disp_valid_i && !full) begin
      e = '0; e.valid = 1; e.payload = disp_payload_i; e.src_tag = disp_src_tag_i;
      e.src_rdy = disp_src_rdy_i; e.is_p2 = disp_is_p2_i; e.p2_tag = disp_p2_tag_i;
      mq.push_back(wake(e));
    end
  endtask

  // inputs already driven after a falling edge
  task automatic step(string req);
    int e_idx;
    bit e_valid, done_ok, e_full;
    #1;
    e_valid = 0; e_idx = 0;
    if (!miss_req_i && !flush_i)
      for (int i = 0; i < mq.size(); i++)
        if (!e_valid && !mq[i].issued && mq[i].src_rdy && (!mq[i].is_p2 || mq[i].p2_rdy)) begin
          e_valid = 1; e_idx = i;
        end
    done_ok = done_valid_i && !flush_i && (int'(done_idx_i) < mq.size());
    e_full = (mq.size() == DEPTH) && !done_ok;
    chk(req, "issue_valid", int'(issue_valid_o), int'(e_valid));
    if (e_valid) begin
      chk(req, "issue_idx", int'(issue_idx_o), e_idx);
      chk(req, "issue_payload", int'(issue_payload_o), int'(mq[e_idx].payload));
    end
    chk(req, "full", int'(full_o), int'(e_full));
    @(posedge clk_i);
    model_update(e_valid ? e_idx : -1, e_full, done_ok);
    @(negedge clk_i);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    step("R10");
    // fill, then one refused dispatch
    for (int k = 0; k <= DEPTH; k++) begin dispatch(k, 0, 0, 0); step("R1"); end
    step("R8");
    nbr_wake_valid_i = 1; nbr_wake_tag_i = 2; step("R4");
    step("R4");
    nbr_wake_valid_i = 1; nbr_wake_tag_i = 0; step("R4");
    miss_req_i = 1; step("R7");
    step("R7");
    step("R6"); step("R6");
    replay_valid_i = 1; replay_idx_i = 2; step("R6");
    step("R6");
    done_valid_i = 1; done_idx_i = 0; dispatch(7, 1, 0, 0); step("R3");
    step("R3"); step("R3");
    done_valid_i = 1; done_idx_i = IDX_W'(DEPTH - 1); step("R3");
    step("R3");
    flush_i = 1; flush_keep_i = 1; dispatch(1, 1, 0, 0); step("R9");
    step("R9");
    flush_i = 1; flush_keep_i = 0; step("R9");
    step("R9");
    dispatch(1, 1, 1, 3); step("R5");
    step("R5");
    p2_wake_valid_i = 1; p2_wake_tag_i = 5; step("R5");
    step("R5");
    p2_wake_valid_i = 1; p2_wake_tag_i = 3; step("R5");
    step("R5");
    dispatch(2, 1, 0, 0); step("R2");
    dispatch(2, 1, 0, 0); step("R2");
    step("R2"); step("R2");
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 9) < 6)
        dispatch($urandom_range(0, 3), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3));
      nbr_wake_valid_i = $urandom_range(0, 9) < 4; nbr_wake_tag_i = SRC_TAG_W'($urandom_range(0, 3));
      p2_wake_valid_i = $urandom_range(0, 9) < 3; p2_wake_tag_i = P2_TAG_W'($urandom_range(0, 3));
      miss_req_i = $urandom_range(0, 99) < 15;
      done_valid_i = $urandom_range(0, 99) < 25; done_idx_i = IDX_W'($urandom_range(0, DEPTH - 1));
      replay_valid_i = $urandom_range(0, 99) < 5; replay_idx_i = IDX_W'($urandom_range(0, DEPTH - 1));
      flush_i = $urandom_range(0, 99) < 3; flush_keep_i = CNT_W'($urandom_range(0, DEPTH));
      step("R2");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule